// File: doc/BRIEF.md
# PTP Time Counter with Fractional Rate Control

This block keeps a 64-bit nanosecond time-of-day count that runs from a fast reference clock. A phase accumulator adds a software-chosen addend to itself every reference cycle. Each carry out of the accumulator is one nominal tick, and each tick adds a programmed period in nanoseconds to the time. Software trims the rate of the time base by rewriting the addend. The addend for a reference-to-tick ratio r is ceil(2^32 / r), and r must exceed 1, so at most one tick can occur per reference cycle.

A prescaler divides the tick stream into a slower output strobe. Two fixed-interval pulse generators count a programmed nanosecond interval down by the period on each tick. Each one emits a pulse one output-clock period wide, and the first is meant to produce one pulse per second. Two asynchronous event inputs stamp the current time into capture registers. One alarm raises a sticky flag when the time reaches a programmed value.

Software uses a plain register port: a one-cycle write strobe, a word address and write data, and read data that follows the address combinationally. The block has no streaming data path, so no port carries valid/ready and there is no back-pressure.

Top module: `ptp_timer`

## Requirements
- R1: After reset the time is 0, both pulse outputs, the strobe and the alarm are low, and the status reads 0. The addend reads 0x80000000 (address 0), the period reads 10 (address 1) and the prescale reads 2 (address 2).
- R2: Every reference cycle the 32-bit accumulator adds the addend modulo 2^32, and a carry is one tick. An addend of 0x80000000 gives a tick every second cycle, 0x40000000 gives one every fourth cycle, and 0 stops the time.
- R3: Each tick adds the 8-bit period register, in nanoseconds, to the 64-bit time.
- R4: A write to address 3 stages the low time word. A write to address 4 loads {written word, staged word} into the time on that same clock edge, and the load takes priority over a tick on that edge. The load also restarts both pulse generators. Addresses 3 and 4 read back the low and high halves of the live time.
- R5: The output strobe is high for one cycle once every prescale ticks.
- R6: A pulse generator with load value L (address 7 for generator 0, address 8 for generator 1) subtracts the period on each tick. On a tick where the remaining value is below the period, it reloads L and its output rises. With L a multiple of the period, the first rise after a restart comes at time T0+L+period, and later rises come every L+period ns.
- R7: Each pulse stays high for prescale × period ns of time.
- R8: A load value of 0 disables its generator, so its output stays low. Writing a load register restarts that generator from the new value.
- R9: Each event input passes through a two-flop synchronizer. On a rising edge, the time present after the second clock edge following the input's rise is latched into that input's capture register (event 0 at addresses 10 and 11, event 1 at addresses 12 and 13, low word first), and a sticky status bit is set (bit 0 for event 0, bit 1 for event 1). An input held high captures nothing further.
- R10: The status register is at address 9. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R11: Writing address 5 stages the low alarm word. Writing address 6 arms the alarm at {written word, staged word}. Once time ≥ alarm, status bit 2 and the alarm output go high.
- R12: The alarm fires once per arming. After it is cleared it stays low even while time ≥ alarm, until address 6 is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 4 | Word address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| evt_i | input | 2 | Asynchronous timestamp event inputs |
| time_o | output | 64 | Current time in nanoseconds |
| out_tick_o | output | 1 | Prescaled output-clock strobe |
| pulse_o | output | 2 | Fixed-interval pulse outputs |
| alarm_o | output | 1 | Sticky alarm flag |

## Verification
On every cycle the embedded properties check the following. The time moves by either zero or one period unless software loads it. Pulses and strobes rise only on a tick. A generator's remaining count never exceeds its load. The alarm rises only once the time has reached the alarm value, and only while armed. An event flag sets only from a synchronized edge. The bench scenarios are needed for everything that depends on the addend and the phase over many cycles: exact rates, where pulses fall relative to a time load, pulse widths in nanoseconds, capture values, clear-on-write behaviour and the once-only alarm.

// File: rtl/ptp_tmr_pkg.sv
package ptp_tmr_pkg;
  localparam int ADDR_W = 4;
  localparam int N_PULSE = 2;
  localparam int N_EVT = 2;
  localparam int ALARM_BIT = 2;

  localparam logic [ADDR_W-1:0] A_ADDEND   = 4'd0;
  localparam logic [ADDR_W-1:0] A_PERIOD   = 4'd1;
  localparam logic [ADDR_W-1:0] A_PRESC    = 4'd2;
  localparam logic [ADDR_W-1:0] A_TIME_LO  = 4'd3;
  localparam logic [ADDR_W-1:0] A_TIME_HI  = 4'd4;
  localparam logic [ADDR_W-1:0] A_ALARM_LO = 4'd5;
  localparam logic [ADDR_W-1:0] A_ALARM_HI = 4'd6;
  localparam logic [ADDR_W-1:0] A_PLS0     = 4'd7;
  localparam logic [ADDR_W-1:0] A_PLS1     = 4'd8;
  localparam logic [ADDR_W-1:0] A_STATUS   = 4'd9;
  localparam logic [ADDR_W-1:0] A_CAP0_LO  = 4'd10;
  localparam logic [ADDR_W-1:0] A_CAP0_HI  = 4'd11;
  localparam logic [ADDR_W-1:0] A_CAP1_LO  = 4'd12;
  localparam logic [ADDR_W-1:0] A_CAP1_HI  = 4'd13;
endpackage

// File: rtl/ptp_phase_accum.sv
module ptp_phase_accum #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] addend_i,
  output logic             tick_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  assign sum    = {1'b0, acc_q} + {1'b0, addend_i};
  assign tick_o = sum[ACC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= sum[ACC_W-1:0];
  end

  // R2: a zero addend freezes the phase
  p_zero_addend_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addend_i == '0) |=> (acc_q == $past(acc_q)));
endmodule

// File: rtl/ptp_pulse_gen.sv
module ptp_pulse_gen #(
  parameter int LOAD_W = 32,
  parameter int PER_W  = 8,
  parameter int PRE_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              restart_i,
  input  logic [LOAD_W-1:0] load_i,
  input  logic [PER_W-1:0]  period_i,
  input  logic [PRE_W-1:0]  presc_i,
  output logic              pulse_o
);
  logic [LOAD_W-1:0] rem_q;
  logic [PRE_W-1:0]  width_q;
  logic [LOAD_W-1:0] per_ext;
  logic              enabled;

  assign per_ext = LOAD_W'(period_i);
  assign enabled = (load_i != '0);
  assign pulse_o = (width_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q   <= '0;
      width_q <= '0;
    end else if (restart_i || !enabled) begin
      rem_q   <= load_i;
      width_q <= '0;
    end else if (tick_i) begin
      if (rem_q < per_ext) begin
        rem_q   <= load_i;
        width_q <= presc_i;
      end else begin
        rem_q <= rem_q - per_ext;
        if (width_q != '0) width_q <= width_q - PRE_W'(1);
      end
    end
  end

  // R6: a pulse only starts on a nominal tick
  p_rise_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |-> $past(tick_i));
  // R6: the countdown never exceeds the programmed interval
  p_rem_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rem_q <= load_i);
  // R8: a disabled generator stays quiet
  p_disabled_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i == '0) |=> !pulse_o);
endmodule

// File: rtl/ptp_evt_capture.sv
module ptp_evt_capture #(
  parameter int TIME_W = 64,
  parameter int SYNC   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_i,
  input  logic [TIME_W-1:0] time_i,
  input  logic              clear_i,
  output logic [TIME_W-1:0] cap_o,
  output logic              flag_o
);
  logic [SYNC:0] sh_q;
  logic          rise;

  assign rise = sh_q[SYNC-1] & ~sh_q[SYNC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cap_o  <= '0;
      flag_o <= 1'b0;
    end else begin
      sh_q <= {sh_q[SYNC-1:0], evt_i};
      if (rise) begin
        cap_o  <= time_i;
        flag_o <= 1'b1;
      end else if (clear_i) begin
        flag_o <= 1'b0;
      end
    end
  end

  // R9: the sticky flag only sets from a synchronized rising edge
  p_flag_from_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> $past(rise));
  // R9: without an edge the capture register holds
  p_cap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(cap_o));
endmodule

// File: rtl/ptp_timer.sv
module ptp_timer
  import ptp_tmr_pkg::*;
#(
  parameter int          DATA_W      = 32,
  parameter int          PER_W       = 8,
  parameter int          PRE_W       = 16,
  parameter int          SYNC_STAGES = 2,
  parameter logic [31:0] RST_ADDEND  = 32'h8000_0000,
  parameter logic [7:0]  RST_PERIOD  = 8'd10,
  parameter logic [15:0] RST_PRESC   = 16'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [N_EVT-1:0]  evt_i,
  output logic [2*DATA_W-1:0] time_o,
  output logic              out_tick_o,
  output logic [N_PULSE-1:0] pulse_o,
  output logic              alarm_o
);
  localparam int TIME_W = 2 * DATA_W;

  logic [DATA_W-1:0] addend_q, time_lo_stage, alarm_lo_stage;
  logic [PER_W-1:0]  period_q;
  logic [PRE_W-1:0]  presc_q, pre_cnt_q;
  logic [TIME_W-1:0] time_q, alarm_q;
  logic              armed_q, alarm_flag_q, out_tick_q, tick;
  logic              time_load, alarm_arm, status_wr;
  logic [DATA_W-1:0] load_q    [N_PULSE];
  logic [DATA_W-1:0] load_next [N_PULSE];
  logic [TIME_W-1:0] cap       [N_EVT];
  logic [N_EVT-1:0]  evt_flag;

  assign time_load = reg_wr && (reg_addr == A_TIME_HI);
  assign alarm_arm = reg_wr && (reg_addr == A_ALARM_HI);
  assign status_wr = reg_wr && (reg_addr == A_STATUS);

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addend_q       <= DATA_W'(RST_ADDEND);
      period_q       <= PER_W'(RST_PERIOD);
      presc_q        <= PRE_W'(RST_PRESC);
      time_lo_stage  <= '0;
      alarm_lo_stage <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_ADDEND:   addend_q       <= reg_wdata;
        A_PERIOD:   period_q       <= reg_wdata[PER_W-1:0];
        A_PRESC:    presc_q        <= reg_wdata[PRE_W-1:0];
        A_TIME_LO:  time_lo_stage  <= reg_wdata;
        A_ALARM_LO: alarm_lo_stage <= reg_wdata;
        default: ;
      endcase
    end
  end

  ptp_phase_accum #(.ACC_W(DATA_W)) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .addend_i (addend_q),
    .tick_o   (tick)
  );

  // time counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         time_q <= '0;
    else if (time_load) time_q <= {reg_wdata, time_lo_stage};
    else if (tick)      time_q <= time_q + TIME_W'(period_q);
  end
  assign time_o = time_q;

  // prescaler on the tick stream
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt_q  <= '0;
      out_tick_q <= 1'b0;
    end else if (tick) begin
      if (pre_cnt_q >= presc_q - PRE_W'(1)) begin
        pre_cnt_q  <= '0;
        out_tick_q <= 1'b1;
      end else begin
        pre_cnt_q  <= pre_cnt_q + PRE_W'(1);
        out_tick_q <= 1'b0;
      end
    end else begin
      out_tick_q <= 1'b0;
    end
  end
  assign out_tick_o = out_tick_q;

  // pulse generators
  for (genvar g = 0; g < N_PULSE; g++) begin : g_pulse
    localparam logic [ADDR_W-1:0] MY_ADDR = A_PLS0 + ADDR_W'(g);
    logic own_wr;
    assign own_wr       = reg_wr && (reg_addr == MY_ADDR);
    assign load_next[g] = own_wr ? reg_wdata : load_q[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) load_q[g] <= '0;
      else        load_q[g] <= load_next[g];
    end

    ptp_pulse_gen #(.LOAD_W(DATA_W), .PER_W(PER_W), .PRE_W(PRE_W)) u_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick),
      .restart_i (own_wr || time_load),
      .load_i    (load_next[g]),
      .period_i  (period_q),
      .presc_i   (presc_q),
      .pulse_o   (pulse_o[g])
    );
  end

  // event timestamp capture
  for (genvar e = 0; e < N_EVT; e++) begin : g_evt
    ptp_evt_capture #(.TIME_W(TIME_W), .SYNC(SYNC_STAGES)) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt_i   (evt_i[e]),
      .time_i  (time_q),
      .clear_i (status_wr && reg_wdata[e]),
      .cap_o   (cap[e]),
      .flag_o  (evt_flag[e])
    );
  end

  // single-shot alarm
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_q      <= '0;
      armed_q      <= 1'b0;
      alarm_flag_q <= 1'b0;
    end else begin
      if (alarm_arm) begin
        alarm_q <= {reg_wdata, alarm_lo_stage};
        armed_q <= 1'b1;
      end else if (armed_q && (time_q >= alarm_q)) begin
        armed_q <= 1'b0;
      end
      if (!alarm_arm && armed_q && (time_q >= alarm_q)) alarm_flag_q <= 1'b1;
      else if (status_wr && reg_wdata[ALARM_BIT])        alarm_flag_q <= 1'b0;
    end
  end
  assign alarm_o = alarm_flag_q;

  // read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_ADDEND:   reg_rdata = addend_q;
      A_PERIOD:   reg_rdata = DATA_W'(period_q);
      A_PRESC:    reg_rdata = DATA_W'(presc_q);
      A_TIME_LO:  reg_rdata = time_q[DATA_W-1:0];
      A_TIME_HI:  reg_rdata = time_q[TIME_W-1:DATA_W];
      A_ALARM_LO: reg_rdata = alarm_q[DATA_W-1:0];
      A_ALARM_HI: reg_rdata = alarm_q[TIME_W-1:DATA_W];
      A_PLS0:     reg_rdata = load_q[0];
      A_PLS1:     reg_rdata = load_q[1];
      A_STATUS:   reg_rdata = DATA_W'({alarm_flag_q, evt_flag});
      A_CAP0_LO:  reg_rdata = cap[0][DATA_W-1:0];
      A_CAP0_HI:  reg_rdata = cap[0][TIME_W-1:DATA_W];
      A_CAP1_LO:  reg_rdata = cap[1][DATA_W-1:0];
      A_CAP1_HI:  reg_rdata = cap[1][TIME_W-1:DATA_W];
      default:    reg_rdata = '0;
    endcase
  end

  // R3: the time moves by nothing or by one period unless loaded
  p_time_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !time_load |=> ((time_q == $past(time_q)) ||
                    (time_q == $past(time_q) + TIME_W'($past(period_q)))));
  // R4: a load places the written value in the time
  p_time_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    time_load |=> (time_q[TIME_W-1:DATA_W] == $past(reg_wdata)));
  // R5: the output strobe follows a tick
  p_strobe_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_tick_q |-> $past(tick));
  // R11: the alarm rises only once the time has reached the alarm value
  p_alarm_due_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag_q) |-> ($past(time_q) >= $past(alarm_q)));
  // R12: firing consumes the arming
  p_alarm_once_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(alarm_flag_q) && !$past(alarm_arm)) |-> !armed_q);
endmodule

// File: tb/test_ptp_timer.sv
module test_ptp_timer;
  import ptp_tmr_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  evt_i = '0;
  logic [63:0] time_o;
  logic        out_tick_o;
  logic [1:0]  pulse_o;
  logic        alarm_o;

  always #4 clk = ~clk;

  ptp_timer i_ptp_timer (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_i(evt_i),
    .time_o(time_o), .out_tick_o(out_tick_o), .pulse_o(pulse_o),
    .alarm_o(alarm_o)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard: expected pulse rise times per generator
  logic [63:0] q0[$];
  logic [63:0] q1[$];
  bit          mon_en = 1'b0;
  logic [1:0]  prev_p = '0;
  logic [63:0] rise_t0 = '0, rise_t1 = '0;

  always @(negedge clk) begin
    if (mon_en) begin
      if (pulse_o[0] && !prev_p[0]) begin
        if (q0.size() == 0) chk(1'b0, "R6", "unexpected pulse0", time_o, 0);
        else begin
          logic [63:0] e0;
          e0 = q0.pop_front();
          chk(time_o == e0, "R6", "pulse0 rise time", time_o, e0);
        end
        rise_t0 = time_o;
      end
      if (!pulse_o[0] && prev_p[0])
        chk(time_o - rise_t0 == 64'd20, "R7", "pulse0 width ns", time_o - rise_t0, 20);
      if (pulse_o[1] && !prev_p[1]) begin
        if (q1.size() == 0) chk(1'b0, "R6", "unexpected pulse1", time_o, 0);
        else begin
          logic [63:0] e1;
          e1 = q1.pop_front();
          chk(time_o == e1, "R6", "pulse1 rise time", time_o, e1);
        end
        rise_t1 = time_o;
      end
      if (!pulse_o[1] && prev_p[1])
        chk(time_o - rise_t1 == 64'd20, "R7", "pulse1 width ns", time_o - rise_t1, 20);
    end
    prev_p = pulse_o;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d, d2;
    logic [63:0] t, t0, ex;
    int cnt;
    bit seen;

    idle(3);
    // R1 reset state
    chk(time_o == 0, "R1", "time at reset", time_o, 0);
    chk(pulse_o == 0 && !out_tick_o && !alarm_o, "R1", "outputs at reset",
        {pulse_o, out_tick_o, alarm_o}, 0);
    rd(A_ADDEND, d); chk(d == 32'h8000_0000, "R1", "addend default", d, 32'h8000_0000);
    rd(A_PERIOD, d); chk(d == 10, "R1", "period default", d, 10);
    rd(A_PRESC, d);  chk(d == 2, "R1", "prescale default", d, 2);
    rd(A_STATUS, d); chk(d == 0, "R1", "status at reset", d, 0);
    @(negedge clk); rst_n = 1'b1;

    // R8 generators with load 0 stay low
    seen = 1'b0;
    repeat (40) begin @(negedge clk); if (pulse_o != 0) seen = 1'b1; end
    chk(!seen, "R8", "disabled generators silent", seen, 0);

    // R4 time load takes the written value
    wr(A_TIME_LO, 32'd1000); wr(A_TIME_HI, 32'd0);
    chk(time_o == 1000, "R4", "time load", time_o, 1000);
    t = time_o; idle(20);
    chk(time_o == t + 100, "R2", "rate at addend 1/2", time_o, t + 100);

    wr(A_ADDEND, 32'h4000_0000);
    rd(A_ADDEND, d); chk(d == 32'h4000_0000, "R2", "addend readback", d, 32'h4000_0000);
    t = time_o; idle(40);
    chk(time_o == t + 100, "R2", "rate at addend 1/4", time_o, t + 100);

    wr(A_ADDEND, 32'h8000_0000); wr(A_PERIOD, 32'd8);
    t = time_o; idle(20);
    chk(time_o == t + 80, "R3", "period 8 ns per tick", time_o, t + 80);

    wr(A_ADDEND, 32'h0);
    t = time_o; idle(30);
    chk(time_o == t, "R2", "zero addend stops time", time_o, t);

    wr(A_ADDEND, 32'h8000_0000); wr(A_PERIOD, 32'd10);
    // R5 strobe every prescale ticks
    cnt = 0;
    repeat (40) begin @(negedge clk); if (out_tick_o) cnt++; end
    chk(cnt == 10, "R5", "strobes in 40 cycles", cnt, 10);

    // R6/R7 pulse generators through the scoreboard
    wr(A_PLS0, 32'd50); wr(A_PLS1, 32'd30);
    wr(A_TIME_LO, 32'd0); wr(A_TIME_HI, 32'd1);
    t0 = 64'h1_0000_0000;
    chk(time_o == t0, "R4", "time load high word", time_o, t0);
    chk(pulse_o == 0, "R4", "restart clears pulses", pulse_o, 0);
    for (int k = 1; k <= 4; k++) q0.push_back(t0 + 64'(60 * k));
    for (int k = 1; k <= 6; k++) q1.push_back(t0 + 64'(40 * k));
    mon_en = 1'b1;
    while (time_o < t0 + 270) @(negedge clk);
    mon_en = 1'b0;
    chk(q0.size() == 0, "R6", "all pulse0 rises seen", q0.size(), 0);
    chk(q1.size() == 0, "R6", "all pulse1 rises seen", q1.size(), 0);

    // R8 load 0 disables generator 1
    wr(A_PLS1, 32'd0);
    seen = 1'b0;
    repeat (40) begin @(negedge clk); if (pulse_o[1]) seen = 1'b1; end
    chk(!seen, "R8", "generator 1 disabled", seen, 0);

    // R9 event capture
    evt_i[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    ex = time_o;
    idle(3);
    rd(A_CAP0_LO, d); rd(A_CAP0_HI, d2);
    chk({d2, d} == ex, "R9", "event0 capture", {d2, d}, ex);
    rd(A_STATUS, d); chk(d == 1, "R9", "event0 status", d, 1);
    evt_i[1] = 1'b1;
    @(negedge clk); @(negedge clk);
    ex = time_o;
    idle(3);
    rd(A_CAP1_LO, d); rd(A_CAP1_HI, d2);
    chk({d2, d} == ex, "R9", "event1 capture", {d2, d}, ex);
    rd(A_STATUS, d); chk(d == 3, "R9", "both event flags", d, 3);
    wr(A_STATUS, 32'd1);
    rd(A_STATUS, d); chk(d == 2, "R10", "clear event0 only", d, 2);
    wr(A_STATUS, 32'd0);
    rd(A_STATUS, d); chk(d == 2, "R10", "write 0 keeps flags", d, 2);
    idle(10);
    rd(A_CAP0_LO, d); rd(A_CAP0_HI, d2);
    rd(A_STATUS, d2);
    chk(d2 == 2, "R9", "held level sets nothing", d2, 2);
    wr(A_STATUS, 32'd2);
    evt_i = '0;

    // R11/R12 alarm
    t = time_o + 200;
    wr(A_ALARM_LO, t[31:0]); wr(A_ALARM_HI, t[63:32]);
    idle(10);
    chk(!alarm_o, "R11", "alarm not yet due", alarm_o, 0);
    idle(60);
    chk(alarm_o, "R11", "alarm fired", alarm_o, 1);
    rd(A_STATUS, d); chk(d == 4, "R11", "alarm status bit", d, 4);
    wr(A_STATUS, 32'd4);
    chk(!alarm_o, "R10", "alarm cleared", alarm_o, 0);
    idle(20);
    chk(!alarm_o, "R12", "no refire without rearm", alarm_o, 0);
    wr(A_ALARM_HI, t[63:32]);
    idle(2);
    chk(alarm_o, "R12", "rearm with past value fires", alarm_o, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule